// File: doc/BRIEF.md
# PTP Seconds Counter with Staged High-Word Load

This block keeps the 48-bit seconds field of an IEEE 1588 time unit. An external nanoseconds counter sends a one-cycle pulse each time it completes a full second, and the block adds one to its count. A separate adjust pulse, with a direction bit, moves the count one second forward or back. The count can step past all ones or below zero, and it wraps around in both cases.

Software reaches the count through two 32-bit registers on a simple single-cycle port. The low-word register covers count bits 31:0. The high-word register covers bits 47:32 in its bits 15:0, and its bits 31:16 read as zero. A write to the high word goes only into a staging register and leaves the live count unchanged. The next low-word write loads the staged 16 bits and the written 32 bits in the same cycle, so the count never holds a half-updated value. A read of the high word returns the live count, not the staged value.

Top module: `ptpsec_top`

## Requirements
- R1: After synchronous reset the count is zero, and both registers read zero.
- R2: A second-tick pulse with no adjust and no load raises the count by one on the next clock edge.
- R3: An adjust pulse with direction 0 adds one to the count. An adjust pulse with direction 1 subtracts one.
- R4: A decrement from zero leaves the count at 0xFFFFFFFFFFFF.
- R5: An increment from 0xFFFFFFFFFFFF leaves the count at zero.
- R6: A write to the high word (address 1) leaves the live count unchanged.
- R7: A write to the low word (address 0) loads the count with {staged high bits, written data} on the next edge. Only bits 15:0 of the last high-word write are staged.
- R8: When a low-word load, a tick and an adjust fall in the same cycle, the count takes the loaded value. The tick and the adjust are dropped.
- R9: A tick and an adjust in the same cycle with no load are combined into one change: +2 when the adjust is up, and no change when it is down.
- R10: A read of address 1 returns count bits 47:32 in bits 15:0 and zero in bits 31:16. It returns the live count even when a different value is staged.
- R11: The staging register resets to zero. A low-word write before any high-word write therefore loads zero into bits 47:32.
- R12: Addresses 2 and 3 are unmapped. They read as zero, and writes to them change neither the count nor the staged high bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick_i | input | 1 | One-second pulse from the nanoseconds counter |
| adj_vld_i | input | 1 | Adjust step request |
| adj_down_i | input | 1 | Adjust direction: 1 steps down, 0 steps up |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address: 0 low word, 1 high word |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i`, combinational |
| sec_count_o | output | 48 | Live seconds count |

## Verification
The tick can fall in the same cycle as the two other sources of change: an adjust pulse, or a software low-word load. The bench drives tick with adjust up and tick with adjust down on single clock edges, and expects net changes of +2 and 0. It then raises a low-word write together with a tick and an adjust, and expects exactly the loaded 48-bit value. Each expectation comes from a reference model that gives the load priority and otherwise adds the signed steps.

// File: rtl/ptpsec_pkg.sv
package ptpsec_pkg;

    // Register decode result
    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_LO   = 2'd1,
        SEL_HI   = 2'd2
    } reg_sel_t;

    // Address map (behaviour depends on it)
    localparam int unsigned ADDR_LO = 0;
    localparam int unsigned ADDR_HI = 1;

    // Net step applied to the count in one cycle
    typedef struct packed {
        logic       load;   // software load wins
        logic       dec;    // subtract one
        logic [1:0] inc;    // add 0, 1 or 2
    } step_t;

    // Decoded register access
    typedef struct packed {
        logic     lo_wr;
        logic     hi_wr;
        reg_sel_t rd_sel;
    } reg_acc_t;

    function automatic step_t merge_step(input logic load,
                                         input logic tick,
                                         input logic adj,
                                         input logic down);
        step_t s;
        s = '0;
        if (load) begin
            s.load = 1'b1;
        end else if (adj && down) begin
            // tick cancels a down step
            s.dec = !tick;
        end else begin
            s.inc = {1'b0, tick} + {1'b0, adj};
        end
        return s;
    endfunction

endpackage

// File: rtl/ptpsec_regif.sv
module ptpsec_regif
    import ptpsec_pkg::*;
#(
    parameter int unsigned ADDR_W = 2
) (
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    output reg_acc_t          acc_o
);

    localparam logic [ADDR_W-1:0] A_LO = ADDR_W'(ADDR_LO);
    localparam logic [ADDR_W-1:0] A_HI = ADDR_W'(ADDR_HI);

    always_comb begin
        acc_o = '0;
        acc_o.rd_sel = SEL_NONE;
        if (addr_i == A_LO) begin
            acc_o.rd_sel = SEL_LO;
            acc_o.lo_wr  = wr_i;
        end else if (addr_i == A_HI) begin
            acc_o.rd_sel = SEL_HI;
            acc_o.hi_wr  = wr_i;
        end
    end

endmodule

// File: rtl/ptpsec_shadow.sv
module ptpsec_shadow #(
    parameter int unsigned HI_W = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_i,
    input  logic [HI_W-1:0] data_i,
    output logic [HI_W-1:0] hold_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_o <= '0;
        end else if (wr_i) begin
            hold_o <= data_i;
        end
    end

endmodule

// File: rtl/ptpsec_count.sv
module ptpsec_count
    import ptpsec_pkg::*;
#(
    parameter int unsigned SEC_W  = 48,
    parameter int unsigned WORD_W = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  step_t                 step_i,
    input  logic [SEC_W-WORD_W-1:0] load_hi_i,
    input  logic [WORD_W-1:0]     load_lo_i,
    output logic [SEC_W-1:0]      cnt_o
);

    logic [SEC_W-1:0] cnt_q;
    logic [SEC_W-1:0] cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (step_i.load) begin
            cnt_d = {load_hi_i, load_lo_i};
        end else if (step_i.dec) begin
            cnt_d = cnt_q - SEC_W'(1);
        end else begin
            cnt_d = cnt_q + SEC_W'(step_i.inc);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o = cnt_q;

endmodule

// File: rtl/ptpsec_top.sv
module ptpsec_top
    import ptpsec_pkg::*;
#(
    parameter int unsigned SEC_W  = 48,
    parameter int unsigned WORD_W = 32,
    parameter int unsigned ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sec_tick_i,
    input  logic              adj_vld_i,
    input  logic              adj_down_i,
    input  logic              reg_wr_i,
    input  logic [ADDR_W-1:0] reg_addr_i,
    input  logic [WORD_W-1:0] reg_wdata_i,
    output logic [WORD_W-1:0] reg_rdata_o,
    output logic [SEC_W-1:0]  sec_count_o
);

    localparam int unsigned HI_W  = SEC_W - WORD_W;
    localparam int unsigned PAD_W = WORD_W - HI_W;

    reg_acc_t        acc;
    step_t           step;
    logic [HI_W-1:0] shadow_hi;
    logic [SEC_W-1:0] count;

    ptpsec_regif #(.ADDR_W(ADDR_W)) u_regif (
        .wr_i   (reg_wr_i),
        .addr_i (reg_addr_i),
        .acc_o  (acc)
    );

    ptpsec_shadow #(.HI_W(HI_W)) u_shadow (
        .clk    (clk),
        .rst    (rst),
        .wr_i   (acc.hi_wr),
        .data_i (reg_wdata_i[HI_W-1:0]),
        .hold_o (shadow_hi)
    );

    assign step = merge_step(acc.lo_wr, sec_tick_i, adj_vld_i, adj_down_i);

    ptpsec_count #(.SEC_W(SEC_W), .WORD_W(WORD_W)) u_count (
        .clk       (clk),
        .rst       (rst),
        .step_i    (step),
        .load_hi_i (shadow_hi),
        .load_lo_i (reg_wdata_i),
        .cnt_o     (count)
    );

    always_comb begin
        unique case (acc.rd_sel)
            SEL_LO:  reg_rdata_o = count[WORD_W-1:0];
            SEL_HI:  reg_rdata_o = {{PAD_W{1'b0}}, count[SEC_W-1:WORD_W]};
            default: reg_rdata_o = '0;
        endcase
    end

    assign sec_count_o = count;

endmodule

// File: rtl/ptpsec_checker.sv
module ptpsec_checker #(
    parameter int unsigned SEC_W  = 48,
    parameter int unsigned WORD_W = 32,
    parameter int unsigned ADDR_W = 2
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    tick,
    input logic                    adj,
    input logic                    down,
    input logic                    wr,
    input logic [ADDR_W-1:0]       addr,
    input logic [WORD_W-1:0]       wdata,
    input logic [WORD_W-1:0]       rdata,
    input logic [SEC_W-1:0]        count,
    input logic [SEC_W-WORD_W-1:0] shadow
);

    localparam int unsigned HI_W = SEC_W - WORD_W;
    logic lo_wr;
    logic hi_wr;
    logic mapped;
    assign lo_wr  = wr && (addr == ADDR_W'(0));
    assign hi_wr  = wr && (addr == ADDR_W'(1));
    assign mapped = (addr == ADDR_W'(0)) || (addr == ADDR_W'(1));

    p_tick_inc_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && !adj && !lo_wr) |=> (count == $past(count) + SEC_W'(1)));

    p_adj_down_r3: assert property (@(posedge clk) disable iff (rst)
        (adj && down && !tick && !lo_wr) |=> (count == $past(count) - SEC_W'(1)));

    p_wrap_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (adj && down && !tick && !lo_wr && count == '0) |=> (count == '1));

    p_hi_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (hi_wr && !tick && !adj) |=> $stable(count));

    p_load_wins_r8: assert property (@(posedge clk) disable iff (rst)
        lo_wr |=> (count == {$past(shadow), $past(wdata)}));

    p_pair_sum_r9: assert property (@(posedge clk) disable iff (rst)
        (tick && adj && !down && !lo_wr) |=> (count == $past(count) + SEC_W'(2)));

    p_hi_read_r10: assert property (@(posedge clk) disable iff (rst)
        (addr == ADDR_W'(1)) |-> (rdata == WORD_W'(count[SEC_W-1:WORD_W])));

    p_unmapped_r12: assert property (@(posedge clk) disable iff (rst)
        (wr && !mapped && !tick && !adj) |=> ($stable(count) && $stable(shadow)));

    p_unmapped_rd_r12: assert property (@(posedge clk) disable iff (rst)
        !mapped |-> (rdata == '0));

    logic unused_hi;
    assign unused_hi = ^wdata[WORD_W-1:HI_W];

endmodule

bind ptpsec_top ptpsec_checker #(
    .SEC_W(SEC_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W)
) chk_i (
    .clk    (clk),
    .rst    (rst),
    .tick   (sec_tick_i),
    .adj    (adj_vld_i),
    .down   (adj_down_i),
    .wr     (reg_wr_i),
    .addr   (reg_addr_i),
    .wdata  (reg_wdata_i),
    .rdata  (reg_rdata_o),
    .count  (sec_count_o),
    .shadow (shadow_hi)
);

// File: tb/ptpsec_top_tb.sv
module ptpsec_top_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sec_tick_i = 1'b0;
    logic        adj_vld_i = 1'b0;
    logic        adj_down_i = 1'b0;
    logic        reg_wr_i = 1'b0;
    logic [1:0]  reg_addr_i = 2'd0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;
    logic [47:0] sec_count_o;

    always #10 clk = ~clk;   // 50 MHz

    ptpsec_top dut_i (
        .clk         (clk),
        .rst         (rst),
        .sec_tick_i  (sec_tick_i),
        .adj_vld_i   (adj_vld_i),
        .adj_down_i  (adj_down_i),
        .reg_wr_i    (reg_wr_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .sec_count_o (sec_count_o)
    );

    typedef struct {
        logic [47:0] val;
        string       tag;
    } exp_t;

    exp_t        sb_q[$];
    int          n_chk  = 0;
    int          n_fail = 0;
    bit          done   = 1'b0;
    logic [47:0] m_cnt  = '0;
    logic [15:0] m_shd  = '0;

    task automatic check(input bit ok, input string tag,
                         input logic [47:0] act, input logic [47:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Driver: one clock of stimulus, expected count pushed to scoreboard
    task automatic cyc(input bit t, input bit av, input bit ad, input bit we,
                       input logic [1:0] a, input logic [31:0] wd, input string tag);
        exp_t e;
        sec_tick_i  = t;
        adj_vld_i   = av;
        adj_down_i  = ad;
        reg_wr_i    = we;
        reg_addr_i  = a;
        reg_wdata_i = wd;
        if (we && a == 2'd0) begin
            m_cnt = {m_shd, wd};
        end else begin
            m_cnt = m_cnt + 48'(t);
            if (av) m_cnt = ad ? m_cnt - 48'd1 : m_cnt + 48'd1;
        end
        if (we && a == 2'd1) m_shd = wd[15:0];
        e.val = m_cnt;
        e.tag = tag;
        sb_q.push_back(e);
        @(posedge clk);
        #3;
        sec_tick_i = 1'b0;
        adj_vld_i  = 1'b0;
        adj_down_i = 1'b0;
        reg_wr_i   = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string tag);
        reg_addr_i = a;
        #2;
        check(reg_rdata_o == exp, tag, 48'(reg_rdata_o), 48'(exp));
        @(negedge clk);
    endtask

    // Monitor: compare count after each driven edge
    always @(posedge clk) begin
        #5;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            check(sec_count_o == e.val, e.tag, sec_count_o, e.val);
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(20 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        #2;
        check(sec_count_o == '0, "R1 count", sec_count_o, '0);
        @(negedge clk);
        rd(2'd0, 32'h0, "R1 lo read");
        rd(2'd1, 32'h0, "R1 hi read");

        // R2: ticks
        for (int i = 0; i < 3; i++) cyc(1, 0, 0, 0, 2'd0, '0, "R2 tick");
        // R3: adjust both directions
        cyc(0, 1, 0, 0, 2'd0, '0, "R3 adj up");
        cyc(0, 1, 1, 0, 2'd0, '0, "R3 adj down");
        // R9: combined tick and adjust
        cyc(1, 1, 0, 0, 2'd0, '0, "R9 tick+up");
        cyc(1, 1, 1, 0, 2'd0, '0, "R9 tick+down");
        // R11: load before any high write
        cyc(0, 0, 0, 1, 2'd0, 32'h0000_0005, "R11 zero shadow load");
        rd(2'd1, 32'h0, "R11 hi read");
        // R4: wrap down from zero
        cyc(0, 0, 0, 1, 2'd0, 32'h0, "R7 load zero");
        cyc(0, 1, 1, 0, 2'd0, '0, "R4 wrap down");
        rd(2'd0, 32'hFFFF_FFFF, "R4 lo read");
        rd(2'd1, 32'h0000_FFFF, "R10 hi read all ones");
        // R5: wrap up by tick and by adjust
        cyc(1, 0, 0, 0, 2'd0, '0, "R5 tick wrap");
        cyc(0, 0, 0, 1, 2'd1, 32'h0000_FFFF, "R6 hi write");
        cyc(0, 0, 0, 1, 2'd0, 32'hFFFF_FFFF, "R7 load all ones");
        cyc(0, 1, 0, 0, 2'd0, '0, "R5 adj wrap");
        // R6 and R10: staged value does not show
        cyc(0, 0, 0, 1, 2'd1, 32'hABCD_1234, "R6 hi write hold");
        rd(2'd1, 32'h0, "R10 live hi not shadow");
        cyc(1, 0, 0, 1, 2'd1, 32'h0000_1234, "R6 hi write with tick");
        // R7: atomic load
        cyc(0, 0, 0, 1, 2'd0, 32'h89AB_CDEF, "R7 atomic load");
        rd(2'd1, 32'h0000_1234, "R7 hi read");
        rd(2'd0, 32'h89AB_CDEF, "R7 lo read");
        // R8: load beats tick and adjust
        cyc(1, 1, 0, 1, 2'd0, 32'h0000_0100, "R8 load+tick+up");
        cyc(1, 1, 1, 1, 2'd0, 32'h0000_0200, "R8 load+tick+down");
        // R12: unmapped addresses
        cyc(0, 0, 0, 1, 2'd2, 32'hFFFF_FFFF, "R12 unmapped write");
        cyc(0, 0, 0, 1, 2'd3, 32'hFFFF_FFFF, "R12 unmapped write 3");
        cyc(0, 0, 0, 1, 2'd0, 32'h0000_0007, "R12 shadow kept");
        rd(2'd2, 32'h0, "R12 read 2");
        rd(2'd3, 32'h0, "R12 read 3");
        // mixed traffic
        for (int i = 0; i < 40; i++) begin
            logic [31:0] r;
            r = $urandom;
            cyc(r[0], r[1], r[2], r[3] & r[4], r[6:5], $urandom, "R9 mixed");
        end
        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule